// File: doc/BRIEF.md
# Irregular Five-Step Counter

This block is a synchronous 3-bit counter that walks a fixed, non-binary cycle of five codes. The state bits are named C (bit 2), B (bit 1) and A (bit 0). On each rising clock edge where the count enable is high, every bit whose toggle term is true flips. The toggle terms are computed from the present code alone. Because every one of the eight codes has a toggle term, the three codes outside the cycle also have a defined successor.

With those toggle terms, the three unused codes chain into one another and never reach the cycle. The counter is therefore not self-starting. A counter that wakes up in one of those codes stays there until it is reset or preset. A valid flag marks when the present code belongs to the cycle.

Reset is active-low. It clears the state asynchronously, and its release is synchronised to the clock through two flops. A preset port writes any code into the state. This stands in for an arbitrary wake-up state, so the behaviour of the unused codes can be observed.

Top module: `nbc_counter`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 000 and `valid_o` is 1. Asserting `rst_ni` low clears the state at once, without waiting for a clock edge, and overrides preset and count.
- R2: After `rst_ni` rises with `count_i` held high, the first two rising edges leave `state_o` at 000. The third rising edge advances it to 010.
- R3: With `count_i` high and `load_i` low, the state follows the cycle 000 → 010 → 011 → 101 → 110 → 000, one step per rising edge.
- R4: With `count_i` and `load_i` both low, `state_o` keeps its value across clock edges, whatever that value is.
- R5: With `count_i` high, the unused codes advance as 001 → 100, 100 → 111 and 111 → 001.
- R6: `valid_o` is 1 exactly when `state_o` is one of 000, 010, 011, 101 or 110. It is 0 for 001, 100 and 111.
- R7: When `load_i` is high on a rising edge, `state_o` takes the value of `load_val_i` on that edge. This holds whether `count_i` is high or low, and preset wins over counting.
- R8: Starting from any unused code with `count_i` held high, the counter never produces a valid code. It returns to its starting code after exactly three steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assertion, synchronised release |
| count_i | input | 1 | Count enable; the state advances one step per edge while high |
| load_i | input | 1 | Preset strobe; writes `load_val_i` into the state |
| load_val_i | input | 3 | Preset code, bit 2 = C, bit 0 = A |
| state_o | output | 3 | Present code, bit 2 = C, bit 0 = A |
| valid_o | output | 1 | High when the present code is one of the five cycle codes |

## Verification
The hardest situation to reach from the ports is the trio of unused codes. Reset and normal counting never leave the five-code cycle, so those codes cannot be reached that way. The bench uses the preset port to put the counter into each of the eight codes and compares one counting step against a reference successor table. From each unused code it then counts freely with a bounded step budget. It reports the closed three-code loop, and that the counter is not self-starting, instead of waiting for a valid code that never comes.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int unsigned NBC_W = 3;
  typedef logic [NBC_W-1:0] nbc_code_t;

  localparam nbc_code_t NBC_RESET_CODE = 3'b000;
  localparam nbc_code_t NBC_IDLE_A     = 3'b001;
  localparam nbc_code_t NBC_IDLE_B     = 3'b100;
  localparam nbc_code_t NBC_IDLE_C     = 3'b111;

  localparam int unsigned NBC_BIT_C = 2;
  localparam int unsigned NBC_BIT_B = 1;
  localparam int unsigned NBC_BIT_A = 0;
endpackage

// File: rtl/nbc_rst_sync.sv
module nbc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[LAST];
endmodule

// File: rtl/nbc_toggle_logic.sv
module nbc_toggle_logic
  import nbc_pkg::*;
(
  input  nbc_code_t state_i,
  output nbc_code_t toggle_o
);
  logic c, b, a;
  logic low_half_odd;

  always_comb begin
    c = state_i[NBC_BIT_C];
    b = state_i[NBC_BIT_B];
    a = state_i[NBC_BIT_A];
    low_half_odd = ~c & (b ^ a);
    toggle_o = '0;
    toggle_o[NBC_BIT_A] = low_half_odd | (c & ~b);
    toggle_o[NBC_BIT_B] = ~low_half_odd;
    toggle_o[NBC_BIT_C] = (~c & a) | (c & b);
  end
endmodule

// File: rtl/nbc_tff_bank.sv
module nbc_tff_bank #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic [WIDTH-1:0] toggle_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      if (load_i) begin
        q_d[i] = load_val_i[i];
      end else if (count_i) begin
        q_d[i] = q_q[i] ^ toggle_i[i];
      end else begin
        q_d[i] = q_q[i];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_q[i] <= 1'b0;
      end else begin
        q_q[i] <= q_d[i];
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/nbc_valid_decode.sv
module nbc_valid_decode
  import nbc_pkg::*;
(
  input  nbc_code_t state_i,
  output logic      valid_o
);
  always_comb begin
    unique case (state_i)
      NBC_IDLE_A, NBC_IDLE_B, NBC_IDLE_C: valid_o = 1'b0;
      default:                            valid_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/nbc_counter.sv
module nbc_counter
  import nbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       count_i,
  input  logic       load_i,
  input  logic [2:0] load_val_i,
  output logic [2:0] state_o,
  output logic       valid_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic      rst_int_n;
  nbc_code_t state_q;
  nbc_code_t toggle;

  nbc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  nbc_toggle_logic u_toggle (
    .state_i  (state_q),
    .toggle_o (toggle)
  );

  nbc_tff_bank #(.WIDTH(NBC_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .count_i    (count_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .toggle_i   (toggle),
    .q_o        (state_q)
  );

  nbc_valid_decode u_valid (
    .state_i (state_q),
    .valid_o (valid_o)
  );

  assign state_o = state_q;
endmodule

// File: rtl/nbc_counter_chk.sv
module nbc_counter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rst_int_n,
  input logic       count_i,
  input logic       load_i,
  input logic [2:0] load_val_i,
  input logic [2:0] state_o,
  input logic       valid_o
);
  assert_reset_clears_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (state_o == 3'b000));

  assert_first_step_R3: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (state_o == 3'b000 && count_i && !load_i) |=> (state_o == 3'b010));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (!count_i && !load_i) |=> $stable(state_o));

  assert_cycle_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (valid_o && count_i && !load_i) |=> valid_o);

  assert_preset_R7: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    load_i |=> (state_o == $past(load_val_i)));

  assert_unused_trapped_R8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (!valid_o && count_i && !load_i) |=> !valid_o);
endmodule

bind nbc_counter nbc_counter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_int_n  (rst_int_n),
  .count_i    (count_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .state_o    (state_o),
  .valid_o    (valid_o)
);

// File: tb/sim_nbc_counter.sv
`timescale 1ns/100ps
module sim_nbc_counter;
  logic       clk;
  logic       rst_n;
  logic       count;
  logic       load;
  logic [2:0] load_val;
  logic [2:0] state;
  logic       valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  nbc_counter u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .count_i    (count),
    .load_i     (load),
    .load_val_i (load_val),
    .state_o    (state),
    .valid_o    (valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [2:0] ref_next(input logic [2:0] s);
    case (s)
      3'b000:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b101;
      3'b101:  return 3'b110;
      3'b110:  return 3'b000;
      3'b001:  return 3'b100;
      3'b100:  return 3'b111;
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic ref_valid(input logic [2:0] s);
    return !(s == 3'b001 || s == 3'b100 || s == 3'b111);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic preset(input logic [2:0] v);
    load = 1'b1;
    load_val = v;
    tick();
    load = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    count = 1'b0;
    load = 1'b0;
    load_val = 3'b000;
    repeat (3) tick();
    check("R1 reset state", state, 0);
    check("R1 reset valid", valid, 1);

    // R2: synchronised release, counting held high
    count = 1'b1;
    rst_n = 1'b1;
    tick();
    check("R2 edge1 after release", state, 0);
    tick();
    check("R2 edge2 after release", state, 0);
    tick();
    check("R2 edge3 after release", state, 3'b010);
    count = 1'b0;

    // R3: walk the cycle twice
    preset(3'b000);
    count = 1'b1;
    for (int i = 0; i < 10; i++) begin
      automatic logic [2:0] exp = ref_next(state);
      tick();
      check("R3 cycle step", state, exp);
    end
    count = 1'b0;

    // R5/R6/R4/R7: every code
    for (int c = 0; c < 8; c++) begin
      preset(3'(c));
      check("R7 preset", state, c);
      check("R6 valid flag", valid, ref_valid(3'(c)));
      tick();
      check("R4 hold", state, c);
      count = 1'b1;
      tick();
      check(ref_valid(3'(c)) ? "R3 successor" : "R5 unused successor",
            state, ref_next(3'(c)));
      count = 1'b0;
    end

    // R7: preset wins over counting
    preset(3'b011);
    count = 1'b1;
    load = 1'b1;
    load_val = 3'b100;
    tick();
    load = 1'b0;
    count = 1'b0;
    check("R7 preset over count", state, 3'b100);

    // R8: unused codes form a closed loop
    for (int c = 0; c < 8; c++) begin
      if (!ref_valid(3'(c))) begin
        automatic int steps = 0;
        automatic int hit_valid = 0;
        preset(3'(c));
        count = 1'b1;
        for (int k = 1; k <= 8; k++) begin
          tick();
          if (valid) hit_valid = 1;
          if (state == 3'(c) && steps == 0) steps = k;
        end
        count = 1'b0;
        check("R8 never valid", hit_valid, 0);
        check("R8 loop length", steps, 3);
        if (hit_valid == 0 && steps == 3)
          $display("note: code %0d is trapped in a three-code loop; counter is not self-starting", c);
      end
    end

    // R1: asynchronous clear between edges
    preset(3'b101);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R1 async clear", state, 0);
    check("R1 async valid", valid, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule